// File: doc/BRIEF.md
# Stretchable External Data Bus Controller

This block sequences data-memory accesses for a processor core. A request carries a 16-bit address, a direction, write data and a flag saying the address came from an 8-bit pointer. An address router first decides where the access lands. Requests for the low 1 KB can be served by an on-chip auxiliary RAM. All other requests, and every request while the auxiliary RAM is switched off, go out on an external bus. On that bus the low address byte and the data share one 8-bit lane, and the high address byte sits on its own 8-bit port.

For external accesses the controller produces an address-latch pulse and separate read and write strobes. Two programmable counts stretch the timing. One count sets how long the address is set up before the latch pulse falls and held after it. The other count sets the width of the strobe. Both counts live in one 8-bit stretch register. Each access finishes with a one-cycle done pulse, and read data is valid in that cycle.

Top module: `xbus_stretch_ctrl`

## Requirements
- R1: After reset the stretch register reads 0x23, with the latch-stretch field A in bits [5:4] equal to 2 and the strobe-stretch field S in bits [2:0] equal to 3. After reset busy, done, ale, rd_stb and wr_stb are all low.
- R2: An external access starts in the clock after acceptance. The accepting edge is the one at which req_valid is high and busy is low. ale is then high for exactly A+1 clocks. During those clocks ad_out carries the low address byte with ad_oe high, and hi_addr carries the high address byte.
- R3: After ale falls, the address stays on ad_out and hi_addr, with ad_oe high, for exactly A+1 clocks before any strobe rises.
- R4: The strobe (rd_stb for reads, wr_stb for writes) stays high for exactly S+1 clocks. ale, rd_stb and wr_stb are never high together.
- R5: ale, rd_stb and wr_stb are low whenever no external access is in progress. Internal accesses never raise them.
- R6: With ram_off=0, addresses 0x0000..0x03FF go to the internal RAM and 0x0400 and above go to the external bus. With ram_off=1, every address goes to the external bus.
- R7: When req_short=1 and ram_off=0, the high address byte is ignored and the internal RAM location equals the low byte. When req_short=1 and ram_off=1, the access is external with the full address driven.
- R8: An internal access raises done in the clock after acceptance, with read data on rdata. It leaves ad_out, ad_oe and hi_addr unchanged.
- R9: External read data is sampled from ad_in on the last clock of rd_stb. It appears on rdata together with a one-clock done pulse that follows the falling strobe. ad_oe is low while rd_stb is high.
- R10: During every clock of wr_stb, ad_out carries the write data and ad_oe is high.
- R11: The stretch fields are captured at acceptance. A write to the stretch register during an access changes only later accesses.
- R12: A request presented while busy is high is ignored. It starts no bus activity and does not change the RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write enable for the stretch register |
| cfg_wdata | input | 8 | Stretch register write value (A in [5:4], S in [2:0]) |
| cfg_rdata | output | 8 | Stretch register contents |
| ram_off | input | 1 | 1 disables the internal auxiliary RAM |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_short | input | 1 | Address came from an 8-bit pointer |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | External access in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with done |
| ad_out | output | 8 | Multiplexed low address / data lane, driven value |
| ad_oe | output | 1 | Drive enable for ad_out |
| ad_in | input | 8 | Multiplexed lane, received value |
| hi_addr | output | 8 | High address byte port |
| ale | output | 1 | Address latch enable |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |

## Verification
Some rules are checked by the assertions on every cycle, with counters in the checker:
- the latch pulse width, the address hold gap and the strobe width, each against the stretch values captured at acceptance;
- the one-hot exclusion of latch and strobes;
- the lane direction during each strobe;
- the done pulse that follows a strobe;
- the quiet bus while the block is idle.

Other behaviour only the bench scenarios can show. These are the address routing at the 0x03FF/0x0400 edge and under ram_off, and the dropped high byte for 8-bit pointers. They also include the data that moves through both RAM paths, the untouched bus during internal accesses, and the effect of a stretch write made mid-access. The last is that requests during busy are dropped.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_HOLD = 3'd2,
    ST_STRB = 3'd3,
    ST_DONE = 3'd4
  } xseq_state_e;
endpackage

// File: rtl/xbus_router.sv
module xbus_router #(
  parameter int ADDR_W    = 16,
  parameter int PTR_W     = 8,
  parameter int RAM_DEPTH = 1024,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              short_ptr,
  input  logic              ram_off,
  output logic              to_int,
  output logic [RAM_AW-1:0] int_addr
);
  localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(RAM_DEPTH);

  logic [ADDR_W-1:0] eff_addr;
  logic              in_window;

  // An 8-bit pointer only reaches the bottom page of the internal RAM
  always_comb begin
    eff_addr  = short_ptr ? ADDR_W'(addr[PTR_W-1:0]) : addr;
    in_window = ({1'b0, addr} < LIMIT);
    to_int    = !ram_off && (short_ptr || in_window);
    int_addr  = eff_addr[RAM_AW-1:0];
  end
endmodule

// File: rtl/xbus_auxram.sv
module xbus_auxram #(
  parameter int DATA_W    = 8,
  parameter int RAM_DEPTH = 1024,
  localparam int RAM_AW   = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              en,
  input  logic              we,
  input  logic [RAM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [RAM_DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq
  import xbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int ALE_SW = 2,
  parameter int STB_SW = 3,
  localparam int CNT_W = (ALE_SW > STB_SW) ? ALE_SW : STB_SW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_write,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_wdata,
  input  logic [ALE_SW-1:0] ale_len,
  input  logic [STB_SW-1:0] stb_len,
  input  logic [DATA_W-1:0] ad_in,
  output logic              busy,
  output logic              seq_done,
  output logic              ale,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  output logic [ADDR_W-DATA_W-1:0] hi_addr,
  output logic [DATA_W-1:0] rdata
);
  xseq_state_e       state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ALE_SW-1:0] ale_len_q;
  logic [STB_SW-1:0] stb_len_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              last_cnt;
  logic              cap_en;

  assign last_cnt = (cnt_q == '0);
  assign cap_en   = (state_q == ST_STRB) && last_cnt && !write_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_ADDR;
        cnt_d   = CNT_W'(ale_len);
      end
      ST_ADDR: if (last_cnt) begin
        state_d = ST_HOLD;
        cnt_d   = CNT_W'(ale_len_q);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
      ST_HOLD: if (last_cnt) begin
        state_d = ST_STRB;
        cnt_d   = CNT_W'(stb_len_q);
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
      ST_STRB: if (last_cnt) begin
        state_d = ST_DONE;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // Access parameters are captured once, when the access is accepted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_len_q <= '0;
      stb_len_q <= '0;
      write_q   <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
    end else if (start && (state_q == ST_IDLE)) begin
      ale_len_q <= ale_len;
      stb_len_q <= stb_len;
      write_q   <= start_write;
      addr_q    <= start_addr;
      wdata_q   <= start_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= ad_in;
  end

  always_comb begin
    busy     = (state_q != ST_IDLE);
    seq_done = (state_q == ST_DONE);
    ale      = (state_q == ST_ADDR);
    rd_stb   = (state_q == ST_STRB) && !write_q;
    wr_stb   = (state_q == ST_STRB) && write_q;
    ad_oe    = (state_q == ST_ADDR) || (state_q == ST_HOLD) || wr_stb;
    ad_out   = wr_stb ? wdata_q : addr_q[DATA_W-1:0];
    hi_addr  = addr_q[ADDR_W-1:DATA_W];
    rdata    = rdata_q;
  end
endmodule

// File: rtl/xbus_stretch_ctrl.sv
module xbus_stretch_ctrl #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          RAM_DEPTH = 1024,
  parameter int          ALE_SW    = 2,
  parameter int          STB_SW    = 3,
  parameter int          ALE_LSB   = 4,
  parameter int          STB_LSB   = 0,
  parameter logic [DATA_W-1:0] CFG_RST = 8'h23,
  localparam int         RAM_AW    = $clog2(RAM_DEPTH),
  localparam int         HI_W      = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  input  logic              ram_off,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_short,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] ad_out,
  output logic              ad_oe,
  input  logic [DATA_W-1:0] ad_in,
  output logic [HI_W-1:0]   hi_addr,
  output logic              ale,
  output logic              rd_stb,
  output logic              wr_stb
);
  logic [ALE_SW-1:0] ale_fld_q;
  logic [STB_SW-1:0] stb_fld_q;
  logic              accept;
  logic              to_int;
  logic [RAM_AW-1:0] int_addr;
  logic              ram_en;
  logic              ext_start;
  logic              int_done_q;
  logic [DATA_W-1:0] ram_rdata;
  logic [DATA_W-1:0] seq_rdata;
  logic              seq_done;

  // Stretch register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_fld_q <= CFG_RST[ALE_LSB +: ALE_SW];
      stb_fld_q <= CFG_RST[STB_LSB +: STB_SW];
    end else if (cfg_we) begin
      ale_fld_q <= cfg_wdata[ALE_LSB +: ALE_SW];
      stb_fld_q <= cfg_wdata[STB_LSB +: STB_SW];
    end
  end

  always_comb begin
    cfg_rdata                    = '0;
    cfg_rdata[ALE_LSB +: ALE_SW] = ale_fld_q;
    cfg_rdata[STB_LSB +: STB_SW] = stb_fld_q;
  end

  assign accept    = req_valid && !busy;
  assign ram_en    = accept && to_int;
  assign ext_start = accept && !to_int;

  xbus_router #(
    .ADDR_W(ADDR_W), .PTR_W(DATA_W), .RAM_DEPTH(RAM_DEPTH)
  ) router_i (
    .addr(req_addr), .short_ptr(req_short), .ram_off(ram_off),
    .to_int(to_int), .int_addr(int_addr)
  );

  xbus_auxram #(
    .DATA_W(DATA_W), .RAM_DEPTH(RAM_DEPTH)
  ) auxram_i (
    .clk(clk), .en(ram_en), .we(req_write), .addr(int_addr),
    .wdata(req_wdata), .rdata(ram_rdata)
  );

  xbus_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ALE_SW(ALE_SW), .STB_SW(STB_SW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n), .start(ext_start), .start_write(req_write),
    .start_addr(req_addr), .start_wdata(req_wdata),
    .ale_len(ale_fld_q), .stb_len(stb_fld_q), .ad_in(ad_in),
    .busy(busy), .seq_done(seq_done), .ale(ale), .rd_stb(rd_stb),
    .wr_stb(wr_stb), .ad_out(ad_out), .ad_oe(ad_oe), .hi_addr(hi_addr),
    .rdata(seq_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) int_done_q <= 1'b0;
    else        int_done_q <= ram_en;
  end

  assign done  = int_done_q | seq_done;
  assign rdata = int_done_q ? ram_rdata : seq_rdata;
endmodule

// File: rtl/xbus_stretch_chk.sv
module xbus_stretch_chk #(
  parameter int ALE_SW = 2,
  parameter int STB_SW = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              ale,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              ad_oe,
  input logic [ALE_SW-1:0] ale_fld,
  input logic [STB_SW-1:0] stb_fld
);
  logic [15:0] cap_a, cap_s;
  logic [15:0] ale_run, gap_run, stb_run;
  logic        stb;

  assign stb = rd_stb || wr_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a   <= '0;
      cap_s   <= '0;
      ale_run <= '0;
      gap_run <= '0;
      stb_run <= '0;
    end else begin
      if (req_valid && !busy) begin
        cap_a <= 16'(ale_fld);
        cap_s <= 16'(stb_fld);
      end
      ale_run <= ale ? ale_run + 16'd1 : 16'd0;
      stb_run <= stb ? stb_run + 16'd1 : 16'd0;
      if (ale)       gap_run <= 16'd0;
      else if (!stb) gap_run <= gap_run + 16'd1;
    end
  end

  assert_idle_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ale && !rd_stb && !wr_stb));
  assert_phase_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ale, rd_stb, wr_stb}));
  assert_wr_drives_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> ad_oe);
  assert_rd_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !ad_oe);
  assert_done_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |-> done);
  assert_ale_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |-> (ale_run == cap_a + 16'd1));
  assert_hold_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb) |-> (gap_run == cap_a + 16'd1));
  assert_stb_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb) |-> (stb_run == cap_s + 16'd1));
endmodule

bind xbus_stretch_ctrl xbus_stretch_chk #(.ALE_SW(ALE_SW), .STB_SW(STB_SW)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy), .done(done),
  .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb), .ad_oe(ad_oe),
  .ale_fld(ale_fld_q), .stb_fld(stb_fld_q)
);

// File: tb/xbus_stretch_ctrl_tb_top.sv
module xbus_stretch_ctrl_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_wdata;
  logic [7:0]  cfg_rdata;
  logic        ram_off;
  logic        req_valid, req_write, req_short;
  logic [15:0] req_addr;
  logic [7:0]  req_wdata;
  logic        busy, done;
  logic [7:0]  rdata;
  logic [7:0]  ad_out;
  logic        ad_oe;
  logic [7:0]  ad_in;
  logic [7:0]  hi_addr;
  logic        ale, rd_stb, wr_stb;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Reference state
  int          q[$];          // bit4 done, bit3 busy, bit2 ale, bit1 rd, bit0 wr, bit5 hold
  int          cur_a, cur_s;
  logic [7:0]  iram [0:1023];
  logic [7:0]  ext_mem [int];
  logic [7:0]  lat_lo;
  logic [15:0] exp_addr;
  logic [7:0]  exp_wd;
  bit          exp_rd_pend;
  logic [7:0]  exp_rd_val;
  logic [7:0]  dummy;

  xbus_stretch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ram_off(ram_off), .req_valid(req_valid),
    .req_write(req_write), .req_short(req_short), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rdata(rdata),
    .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in), .hi_addr(hi_addr),
    .ale(ale), .rd_stb(rd_stb), .wr_stb(wr_stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] ext_val(int a);
    if (ext_mem.exists(a)) return ext_mem[a];
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One clock: advance past the edge, compare with the reference
  task automatic tick();
    int e;
    logic [4:0] got;
    @(posedge clk);
    #2;
    e = (q.size() != 0) ? q.pop_front() : 0;
    got = {done, busy, ale, rd_stb, wr_stb};
    chk(got == e[4:0], "R4 phase pattern (R2 R5)", int'(got), e & 31);
    if (ale) begin
      lat_lo = ad_out;
      chk(ad_oe && ad_out == exp_addr[7:0] && hi_addr == exp_addr[15:8],
          "R2 address during ale", {hi_addr, ad_out}, exp_addr);
    end
    if (e[5])
      chk(ad_oe && ad_out == exp_addr[7:0] && hi_addr == exp_addr[15:8],
          "R3 address hold", {hi_addr, ad_out}, exp_addr);
    if (wr_stb) begin
      chk(ad_oe && ad_out == exp_wd, "R10 write data on lane", ad_out, exp_wd);
      ext_mem[{16'd0, hi_addr, lat_lo}] = ad_out;
    end
    if (done && exp_rd_pend) begin
      chk(rdata == exp_rd_val, "R9 read data", rdata, exp_rd_val);
      exp_rd_pend = 0;
    end
    ad_in = ext_val({16'd0, hi_addr, lat_lo});
  endtask

  task automatic set_cfg(logic [7:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
    cur_a = int'(v[5:4]); cur_s = int'(v[2:0]);
  endtask

  task automatic access(bit wr, bit sh, logic [15:0] a, logic [7:0] d,
                        int mid_cfg, bit poke, output logic [7:0] rd);
    bit internal;
    logic [9:0] ia;
    logic [16:0] snap;
    while (busy) tick();
    internal = !ram_off && (sh || a < 16'h0400);
    ia = sh ? {2'b00, a[7:0]} : a[9:0];
    req_valid = 1'b1; req_write = wr; req_short = sh;
    req_addr = a; req_wdata = d;
    snap = {ad_oe, hi_addr, ad_out};
    if (internal) begin
      q.push_back(32'h10);
      if (wr) iram[ia] = d;
      else begin exp_rd_pend = 1; exp_rd_val = iram[ia]; end
    end else begin
      exp_addr = a; exp_wd = d;
      for (int i = 0; i <= cur_a; i++) q.push_back(32'h0C);
      for (int i = 0; i <= cur_a; i++) q.push_back(32'h28);
      for (int i = 0; i <= cur_s; i++) q.push_back(wr ? 32'h09 : 32'h0A);
      q.push_back(32'h18);
      if (!wr) begin exp_rd_pend = 1; exp_rd_val = ext_val(int'(a)); end
    end
    rd = exp_rd_val;
    tick();
    req_valid = 1'b0;
    if (mid_cfg >= 0) set_cfg(8'(mid_cfg));
    if (poke) begin
      // R12: request while busy, internal write that must be dropped
      req_valid = 1'b1; req_write = 1'b1; req_short = 1'b0;
      req_addr = 16'h0010; req_wdata = 8'hEE;
      tick(); tick();
      req_valid = 1'b0;
    end
    while (q.size() != 0) tick();
    if (internal)
      chk({ad_oe, hi_addr, ad_out} == snap, "R8 bus unchanged on internal access",
          int'({ad_oe, hi_addr, ad_out}), int'(snap));
    chk(exp_rd_pend == 0, "R9 done seen for read", int'(exp_rd_pend), 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_wdata = '0; ram_off = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_short = 1'b0;
    req_addr = '0; req_wdata = '0; ad_in = '0; lat_lo = '0;
    exp_addr = '0; exp_wd = '0; exp_rd_pend = 0; exp_rd_val = '0;
    cur_a = 2; cur_s = 3;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(cfg_rdata == 8'h23, "R1 stretch reset value", cfg_rdata, 8'h23);
    chk({busy, done, ale, rd_stb, wr_stb} == 5'b0, "R1 idle outputs",
        int'({busy, done, ale, rd_stb, wr_stb}), 0);

    // Default stretch: external write then read (R2 R3 R4 R10 R9)
    access(1, 0, 16'h1234, 8'hA7, -1, 0, dummy);
    access(0, 0, 16'h1234, 8'h00, -1, 0, dummy);
    access(0, 0, 16'h8001, 8'h00, -1, 0, dummy);

    // Minimum stretch, boundary address 0x0400 is external (R6)
    set_cfg(8'h00);
    access(1, 0, 16'h0400, 8'h3C, -1, 0, dummy);
    access(0, 0, 16'h0400, 8'h00, -1, 0, dummy);

    // Maximum stretch (R2 R4)
    set_cfg(8'h37);
    access(0, 0, 16'hFFFF, 8'h00, -1, 0, dummy);
    access(1, 0, 16'hC0DE, 8'h5E, -1, 0, dummy);

    // Internal RAM at top of window (R6 R8)
    access(1, 0, 16'h03FF, 8'hB1, -1, 0, dummy);
    access(0, 0, 16'h03FF, 8'h00, -1, 0, dummy);
    access(1, 0, 16'h0010, 8'h11, -1, 0, dummy);

    // Short pointer with RAM on ignores high byte (R7)
    access(1, 1, 16'hAB12, 8'h77, -1, 0, dummy);
    access(0, 0, 16'h0012, 8'h00, -1, 0, dummy);

    // RAM off: low addresses and short pointers go external (R6 R7)
    ram_off = 1'b1;
    set_cfg(8'h11);
    access(1, 0, 16'h0010, 8'h99, -1, 0, dummy);
    access(0, 1, 16'hAB12, 8'h00, -1, 0, dummy);
    ram_off = 1'b0;
    access(0, 0, 16'h0010, 8'h00, -1, 0, dummy);
    chk(iram[10'h010] == 8'h11, "R6 internal copy kept", iram[10'h010], 8'h11);

    // Stretch write mid-access takes effect next time (R11)
    set_cfg(8'h23);
    access(0, 0, 16'h2222, 8'h00, 8'h01, 0, dummy);
    access(1, 0, 16'h2223, 8'h4D, -1, 0, dummy);
    chk(cfg_rdata == 8'h01, "R11 new stretch value", cfg_rdata, 8'h01);

    // Request during busy is dropped (R12)
    set_cfg(8'h23);
    access(0, 0, 16'h5000, 8'h00, -1, 1, dummy);
    access(0, 0, 16'h0010, 8'h00, -1, 0, dummy);

    repeat (3) tick();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule